// File: doc/BRIEF.md
# Host Controller Configuration and Interrupt Register Block

This block is a small 32-bit register file placed beside a USB host controller. A simple register bus with a write strobe and a read strobe sets static configuration signals for the controller: a filter bypass nibble, five port strap bits, the frame length adjust value, an endianness select, a coherency enable, a bus master enable and an error response enable. A 32-bit general register is also provided. Only full-word accesses are supported, and data is little-endian.

The block also contains a two-source interrupt controller. A pulse on the address decode error input or on the host system error input sets a sticky status bit. Software clears a status bit by writing 1 to it. The mask register cannot be written directly. Software changes it only through two command registers: writing a 1 to the enable command unmasks the matching source, and writing a 1 to the disable command masks it. A single registered level interrupt line is high while any unmasked status bit is set.

The byte offsets are: filter bypass 0x30, port straps 0x34, frame adjust 0x38, endian select 0x40, coherency 0x44, bus master enable 0x48, error response control 0x60, interrupt status 0x64, interrupt mask 0x68, enable command 0x6C, disable command 0x70, general register 0x78. All other offsets, including offsets that are not word aligned, are unmapped.

Top module: `usbctl_cfg_regs`

## Requirements
- R1: After reset, the frame adjust field is 0x20, bus master enable is 1, the interrupt mask is 0x3, the interrupt line is low, and every other register and configuration output is 0.
- R2: A write to a configuration register stores only that register's defined field. The fields are filter bypass in bits [3:0], port straps in bits [4:0], frame adjust in bits [5:0], and bit 0 of the endian, coherency, bus master and error response registers. The stored value drives the matching output from the next cycle. Reserved bits read as 0.
- R3: When bus_rd_en is high, bus_rdata shows the register at bus_addr after the next clock edge, and it holds that value until the next read.
- R4: A read of an unmapped offset returns 0. A write to an unmapped offset changes no register and no output.
- R5: A pulse on evt_addr_dec_err sets status bit 0, and a pulse on evt_host_sys_err sets status bit 1. A status bit stays set until software clears it.
- R6: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R7: If an event and a write-1-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R8: Writes to the mask register at 0x68 are ignored.
- R9: Writing 1s to the enable command at 0x6C clears the matching mask bits. Writing 1s to the disable command at 0x70 sets them. Both command registers read as 0.
- R10: irq_o is high one cycle after any status bit is set while its mask bit is clear, and low one cycle after no such bit remains.
- R11: The register at 0x78 stores and returns all 32 bits of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per access |
| bus_rd_en | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| evt_addr_dec_err | input | 1 | Address decode error event pulse |
| evt_host_sys_err | input | 1 | Host system error event pulse |
| cfg_filter_bypass | output | 4 | Filter bypass controls |
| cfg_port_straps | output | 5 | Port strap bits |
| cfg_frame_adj | output | 6 | Frame length adjust value |
| cfg_big_endian | output | 1 | Endianness select |
| cfg_coherent | output | 1 | Coherency enable |
| cfg_bus_master_en | output | 1 | Bus master enable |
| cfg_err_resp_en | output | 1 | Error response enable |
| irq_o | output | 1 | Level interrupt line |

## Verification
The assertions assume one access at a time. A write changes only the register that the offset decodes, and events are sampled as plain synchronous levels. The stimulus therefore drives every strobe, address and event from the falling clock edge, holds it for exactly one cycle, and then returns it to idle. The one deliberate overlap is an event pulse in the same cycle as a clearing write, which checks the set-wins rule. The bench also compares every output on every cycle against a behavioural model of the registers.

// File: rtl/usbctl_cfg_pkg.sv
package usbctl_cfg_pkg;
   localparam int REG_W   = 32;
   localparam int N_REGS  = 12;
   localparam int N_SRC   = 2;
   localparam int FILT_W  = 4;
   localparam int PORT_W  = 5;
   localparam int FLADJ_W = 6;
   localparam logic [FLADJ_W-1:0] FLADJ_RST = 6'h20;
   localparam logic [N_SRC-1:0]   MASK_RST  = '1;

   // register slot indices
   localparam int IX_FILT   = 0;
   localparam int IX_PORT   = 1;
   localparam int IX_FLADJ  = 2;
   localparam int IX_ENDIAN = 3;
   localparam int IX_COHER  = 4;
   localparam int IX_BME    = 5;
   localparam int IX_ERRCTL = 6;
   localparam int IX_STAT   = 7;
   localparam int IX_MASK   = 8;
   localparam int IX_EN     = 9;
   localparam int IX_DIS    = 10;
   localparam int IX_AUX    = 11;

   function automatic logic [7:0] reg_offset(input int ix);
      case (ix)
         IX_FILT:   return 8'h30;
         IX_PORT:   return 8'h34;
         IX_FLADJ:  return 8'h38;
         IX_ENDIAN: return 8'h40;
         IX_COHER:  return 8'h44;
         IX_BME:    return 8'h48;
         IX_ERRCTL: return 8'h60;
         IX_STAT:   return 8'h64;
         IX_MASK:   return 8'h68;
         IX_EN:     return 8'h6C;
         IX_DIS:    return 8'h70;
         default:   return 8'h78;
      endcase
   endfunction
endpackage

// File: rtl/usbctl_addr_dec.sv
module usbctl_addr_dec
   import usbctl_cfg_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [N_REGS-1:0] sel
);
   if (ADDR_W < 7) begin : g_bad_addr_w
      $error("usbctl_addr_dec: ADDR_W must be at least 7");
   end

   for (genvar g = 0; g < N_REGS; g++) begin : g_slot
      assign sel[g] = (addr == ADDR_W'(reg_offset(g)));
   end
endmodule

// File: rtl/usbctl_cfg_bank.sv
module usbctl_cfg_bank
   import usbctl_cfg_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [N_REGS-1:0]    sel,
   input  logic [REG_W-1:0]     wdata,
   output logic [FILT_W-1:0]    filt_q,
   output logic [PORT_W-1:0]    port_q,
   output logic [FLADJ_W-1:0]   fladj_q,
   output logic                 endian_q,
   output logic                 coher_q,
   output logic                 bme_q,
   output logic                 errctl_q,
   output logic [REG_W-1:0]     aux_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q   <= '0;
         port_q   <= '0;
         fladj_q  <= FLADJ_RST;
         endian_q <= 1'b0;
         coher_q  <= 1'b0;
         bme_q    <= 1'b1;
         errctl_q <= 1'b0;
         aux_q    <= '0;
      end else if (wr_en) begin
         if (sel[IX_FILT])   filt_q   <= wdata[FILT_W-1:0];
         if (sel[IX_PORT])   port_q   <= wdata[PORT_W-1:0];
         if (sel[IX_FLADJ])  fladj_q  <= wdata[FLADJ_W-1:0];
         if (sel[IX_ENDIAN]) endian_q <= wdata[0];
         if (sel[IX_COHER])  coher_q  <= wdata[0];
         if (sel[IX_BME])    bme_q    <= wdata[0];
         if (sel[IX_ERRCTL]) errctl_q <= wdata[0];
         if (sel[IX_AUX])    aux_q    <= wdata;
      end
   end

   // R2
   fladj_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel[IX_FLADJ]) |=> (fladj_q == $past(wdata[FLADJ_W-1:0])));

   // R4
   unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !(|sel)) |=>
         $stable({filt_q, port_q, fladj_q, endian_q, coher_q, bme_q, errctl_q, aux_q}));
endmodule

// File: rtl/usbctl_irq_ctrl.sv
module usbctl_irq_ctrl
   import usbctl_cfg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             sel_stat,
   input  logic             sel_mask,
   input  logic             sel_en,
   input  logic             sel_dis,
   input  logic [N_SRC-1:0] wbits,
   input  logic [N_SRC-1:0] evt,
   output logic [N_SRC-1:0] stat_q,
   output logic [N_SRC-1:0] mask_q,
   output logic             irq_q
);
   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      logic clr_hit, en_hit, dis_hit;
      assign clr_hit = wr_en && sel_stat && wbits[i];
      assign en_hit  = wr_en && sel_en   && wbits[i];
      assign dis_hit = wr_en && sel_dis  && wbits[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         stat_q[i] <= 1'b0;
         else if (evt[i])    stat_q[i] <= 1'b1;
         else if (clr_hit)   stat_q[i] <= 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         mask_q[i] <= MASK_RST[i];
         else if (en_hit)    mask_q[i] <= 1'b0;
         else if (dis_hit)   mask_q[i] <= 1'b1;
      end

      // R5
      evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> stat_q[i]);

      // R6
      w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_hit && !evt[i]) |=> !stat_q[i]);

      // R9
      dis_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
         dis_hit |=> mask_q[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(stat_q & ~mask_q);
   end

   // R8
   mask_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_mask) |=> $stable(mask_q));

   // R10
   irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stat_q & ~mask_q)) |=> irq_q);
endmodule

// File: rtl/usbctl_cfg_regs.sv
module usbctl_cfg_regs
   import usbctl_cfg_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter bit READ_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr_en,
   input  logic               bus_rd_en,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic               evt_addr_dec_err,
   input  logic               evt_host_sys_err,
   output logic [FILT_W-1:0]  cfg_filter_bypass,
   output logic [PORT_W-1:0]  cfg_port_straps,
   output logic [FLADJ_W-1:0] cfg_frame_adj,
   output logic               cfg_big_endian,
   output logic               cfg_coherent,
   output logic               cfg_bus_master_en,
   output logic               cfg_err_resp_en,
   output logic               irq_o
);
   if (DATA_W != REG_W) begin : g_bad_data_w
      $error("usbctl_cfg_regs: DATA_W must equal 32");
   end

   logic [N_REGS-1:0]            sel;
   logic [N_SRC-1:0]             stat_q, mask_q;
   logic [REG_W-1:0]             aux_q;
   logic [N_REGS-1:0][REG_W-1:0] rview;
   logic [REG_W-1:0]             rmux;

   usbctl_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   usbctl_cfg_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr_en),
      .sel      (sel),
      .wdata    (bus_wdata),
      .filt_q   (cfg_filter_bypass),
      .port_q   (cfg_port_straps),
      .fladj_q  (cfg_frame_adj),
      .endian_q (cfg_big_endian),
      .coher_q  (cfg_coherent),
      .bme_q    (cfg_bus_master_en),
      .errctl_q (cfg_err_resp_en),
      .aux_q    (aux_q)
   );

   usbctl_irq_ctrl u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr_en),
      .sel_stat (sel[IX_STAT]),
      .sel_mask (sel[IX_MASK]),
      .sel_en   (sel[IX_EN]),
      .sel_dis  (sel[IX_DIS]),
      .wbits    (bus_wdata[N_SRC-1:0]),
      .evt      ({evt_host_sys_err, evt_addr_dec_err}),
      .stat_q   (stat_q),
      .mask_q   (mask_q),
      .irq_q    (irq_o)
   );

   // zero-extended view of every slot; command slots read as zero
   always_comb begin
      rview            = '0;
      rview[IX_FILT]   = REG_W'(cfg_filter_bypass);
      rview[IX_PORT]   = REG_W'(cfg_port_straps);
      rview[IX_FLADJ]  = REG_W'(cfg_frame_adj);
      rview[IX_ENDIAN] = REG_W'(cfg_big_endian);
      rview[IX_COHER]  = REG_W'(cfg_coherent);
      rview[IX_BME]    = REG_W'(cfg_bus_master_en);
      rview[IX_ERRCTL] = REG_W'(cfg_err_resp_en);
      rview[IX_STAT]   = REG_W'(stat_q);
      rview[IX_MASK]   = REG_W'(mask_q);
      rview[IX_AUX]    = aux_q;
   end

   always_comb begin
      rmux = '0;
      for (int k = 0; k < N_REGS; k++) begin
         if (sel[k]) rmux = rmux | rview[k];
      end
   end

   if (READ_REG) begin : g_rd_reg
      logic [REG_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         rdata_q <= '0;
         else if (bus_rd_en) rdata_q <= rmux;
      end
      assign bus_rdata = rdata_q;

      // R4
      unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd_en && !(|sel)) |=> (bus_rdata == '0));

      // R3
      rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !bus_rd_en |=> $stable(bus_rdata));
   end else begin : g_rd_comb
      assign bus_rdata = rmux;
   end
endmodule

// File: tb/usbctl_cfg_regs_tb.sv
module usbctl_cfg_regs_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        ev_ad = 1'b0, ev_hs = 1'b0;
   logic [3:0]  o_filt;
   logic [4:0]  o_port;
   logic [5:0]  o_fl;
   logic        o_end, o_coh, o_bme, o_err, o_irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usbctl_cfg_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
      .evt_addr_dec_err(ev_ad), .evt_host_sys_err(ev_hs),
      .cfg_filter_bypass(o_filt), .cfg_port_straps(o_port),
      .cfg_frame_adj(o_fl), .cfg_big_endian(o_end), .cfg_coherent(o_coh),
      .cfg_bus_master_en(o_bme), .cfg_err_resp_en(o_err), .irq_o(o_irq)
   );

   // behavioural reference model
   logic [3:0]  m_filt;
   logic [4:0]  m_port;
   logic [5:0]  m_fl;
   logic        m_end, m_coh, m_bme, m_err, m_irq;
   logic [31:0] m_aux, m_rdata;
   logic [1:0]  m_stat, m_mask, t_stat, t_mask;

   function automatic logic [31:0] model_read(input logic [7:0] a);
      case (a)
         8'h30: return {28'd0, m_filt};
         8'h34: return {27'd0, m_port};
         8'h38: return {26'd0, m_fl};
         8'h40: return {31'd0, m_end};
         8'h44: return {31'd0, m_coh};
         8'h48: return {31'd0, m_bme};
         8'h60: return {31'd0, m_err};
         8'h64: return {30'd0, m_stat};
         8'h68: return {30'd0, m_mask};
         8'h78: return m_aux;
         default: return 32'd0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_filt <= 0; m_port <= 0; m_fl <= 6'h20; m_end <= 0; m_coh <= 0;
         m_bme <= 1; m_err <= 0; m_aux <= 0; m_stat <= 0; m_mask <= 2'b11;
         m_irq <= 0; m_rdata <= 0;
      end else begin
         t_stat = m_stat;
         t_mask = m_mask;
         if (wr_en) begin
            case (addr)
               8'h30: m_filt <= wdata[3:0];
               8'h34: m_port <= wdata[4:0];
               8'h38: m_fl   <= wdata[5:0];
               8'h40: m_end  <= wdata[0];
               8'h44: m_coh  <= wdata[0];
               8'h48: m_bme  <= wdata[0];
               8'h60: m_err  <= wdata[0];
               8'h64: t_stat = t_stat & ~wdata[1:0];
               8'h6C: t_mask = t_mask & ~wdata[1:0];
               8'h70: t_mask = t_mask | wdata[1:0];
               8'h78: m_aux  <= wdata;
               default: ;
            endcase
         end
         t_stat = t_stat | {ev_hs, ev_ad};
         m_stat <= t_stat;
         m_mask <= t_mask;
         m_irq  <= |(m_stat & ~m_mask);
         if (rd_en) m_rdata <= model_read(addr);
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         chk(o_filt == m_filt && o_port == m_port && o_fl == m_fl, "R2 cfg fields",
             {14'd0, o_fl, o_port, 3'd0, o_filt}, {14'd0, m_fl, m_port, 3'd0, m_filt});
         chk({o_end, o_coh, o_bme, o_err} == {m_end, m_coh, m_bme, m_err}, "R2 cfg bits",
             {28'd0, o_end, o_coh, o_bme, o_err}, {28'd0, m_end, m_coh, m_bme, m_err});
         chk(o_irq == m_irq, "R10 irq", {31'd0, o_irq}, {31'd0, m_irq});
         chk(rdata == m_rdata, "R3 rdata", rdata, m_rdata);
      end
   end

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic rd_expect(input logic [7:0] a, input logic [31:0] e, input string req);
      logic [31:0] d;
      bus_rd(a, d);
      chk(d == e, req, d, e);
   endtask

   task automatic pulse(input logic ad, input logic hs);
      ev_ad = ad; ev_hs = hs;
      @(negedge clk);
      ev_ad = 1'b0; ev_hs = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(o_irq == 1'b0, "R1 irq low", {31'd0, o_irq}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_expect(8'h38, 32'h20, "R1 frame adj");
      rd_expect(8'h48, 32'h1,  "R1 bus master");
      rd_expect(8'h68, 32'h3,  "R1 mask");
      rd_expect(8'h30, 32'h0,  "R1 filter");
      rd_expect(8'h64, 32'h0,  "R1 status");
      rd_expect(8'h78, 32'h0,  "R1 general");

      // R2 field widths and reserved bits
      bus_wr(8'h30, 32'hFFFF_FFFF);
      rd_expect(8'h30, 32'hF, "R2 filter readback");
      chk(o_filt == 4'hF, "R2 filter out", {28'd0, o_filt}, 32'hF);
      bus_wr(8'h34, 32'hFFFF_FFF5);
      rd_expect(8'h34, 32'h15, "R2 port readback");
      chk(o_port == 5'h15, "R2 port out", {27'd0, o_port}, 32'h15);
      bus_wr(8'h38, 32'hABCD_EF3F);
      rd_expect(8'h38, 32'h3F, "R2 frame adj");
      bus_wr(8'h40, 32'hFFFF_FFFF);
      bus_wr(8'h44, 32'h0000_0003);
      bus_wr(8'h48, 32'hFFFF_FFFE);
      bus_wr(8'h60, 32'h8000_0001);
      rd_expect(8'h40, 32'h1, "R2 endian");
      rd_expect(8'h48, 32'h0, "R2 bus master cleared");
      chk({o_end, o_coh, o_bme, o_err} == 4'b1101, "R2 bits out",
          {28'd0, o_end, o_coh, o_bme, o_err}, 32'hD);

      // R11 general register
      bus_wr(8'h78, 32'hDEAD_BEEF);
      rd_expect(8'h78, 32'hDEAD_BEEF, "R11 general");

      // R4 unmapped
      bus_wr(8'h3C, 32'hFFFF_FFFF);
      bus_wr(8'h31, 32'h0);
      bus_wr(8'h7C, 32'h0);
      rd_expect(8'h3C, 32'h0, "R4 unmapped read");
      rd_expect(8'h79, 32'h0, "R4 misaligned read");
      rd_expect(8'h30, 32'hF, "R4 filter untouched");
      rd_expect(8'h78, 32'hDEAD_BEEF, "R4 general untouched");

      // R5 event while masked
      pulse(1'b1, 1'b0);
      rd_expect(8'h64, 32'h1, "R5 status bit0");
      chk(o_irq == 1'b0, "R5 masked no irq", {31'd0, o_irq}, 32'd0);

      // R8 mask writes ignored
      bus_wr(8'h68, 32'h0);
      rd_expect(8'h68, 32'h3, "R8 mask unchanged");
      chk(o_irq == 1'b0, "R8 irq still low", {31'd0, o_irq}, 32'd0);

      // R9 enable command
      bus_wr(8'h6C, 32'h1);
      rd_expect(8'h68, 32'h2, "R9 mask after enable");
      rd_expect(8'h6C, 32'h0, "R9 enable reads zero");
      chk(o_irq == 1'b1, "R10 irq high", {31'd0, o_irq}, 32'd1);

      // R6 write zero keeps, write one clears
      bus_wr(8'h64, 32'h0);
      rd_expect(8'h64, 32'h1, "R6 write 0 keeps");
      bus_wr(8'h64, 32'h1);
      rd_expect(8'h64, 32'h0, "R6 write 1 clears");
      chk(o_irq == 1'b0, "R10 irq low after clear", {31'd0, o_irq}, 32'd0);

      // R7 set wins over clear
      bus_wr(8'h6C, 32'h2);
      pulse(1'b0, 1'b1);
      ev_hs = 1'b1;
      bus_wr(8'h64, 32'h2);
      ev_hs = 1'b0;
      rd_expect(8'h64, 32'h2, "R7 set wins");
      chk(o_irq == 1'b1, "R10 irq from bit1", {31'd0, o_irq}, 32'd1);

      // R9 disable command
      bus_wr(8'h70, 32'hFFFF_FFFF);
      rd_expect(8'h68, 32'h3, "R9 mask after disable");
      rd_expect(8'h70, 32'h0, "R9 disable reads zero");
      chk(o_irq == 1'b0, "R9 irq masked", {31'd0, o_irq}, 32'd0);

      // both sources, unmask all, clear all
      pulse(1'b1, 1'b1);
      bus_wr(8'h6C, 32'h3);
      rd_expect(8'h64, 32'h3, "R5 both set");
      bus_wr(8'h64, 32'h3);
      @(negedge clk);
      rd_expect(8'h64, 32'h0, "R6 both cleared");
      chk(o_irq == 1'b0, "R10 irq dropped", {31'd0, o_irq}, 32'd0);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule